// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit processor with fixed 4-byte instructions fetches next. Each cycle it receives the current program counter, a small code for the control class of the current instruction, two register operands, the 16-bit branch offset field, the 26-bit jump field and a destination register index. From these it produces the next program counter, a flag that says control left the sequential path, and the register write that a linking jump needs: an enable, the destination index and the return address.

The block is purely combinational. It sits between the decoder and the PC register. Branch conditions use only an equality comparator and a sign-bit or zero test, so no subtractor is needed. The sequential adder output serves as the link value, as the base of the branch target, and as the source of the upper bits of the direct jump target.

Top module: `next_pc_unit`

## Requirements
- R1: For class code 0 (sequential) and for every unused code 11 to 15, next_pc is pc+4, taken is 0, link_we is 0 and link_rd is 0.
- R2: Code 1 (branch if opa equals opb) and code 2 (branch if opa differs from opb) are taken exactly when their equality test holds.
- R3: Codes 3 (opa > 0), 4 (opa >= 0), 5 (opa < 0) and 6 (opa <= 0) treat opa as a signed 32-bit value and are taken exactly when the comparison holds.
- R4: A taken branch sets next_pc to pc + 4 + (sign-extended imm16 shifted left by 2). A branch that is not taken sets next_pc to pc + 4.
- R5: Code 7 (direct jump) sets next_pc to {bits 31:28 of pc+4, tgt26, 2'b00}.
- R6: Code 9 (register jump) sets next_pc to opa.
- R7: Code 8 (direct jump with link) jumps as in R5, sets link_we to 1 and link_rd to 31.
- R8: Code 10 (register jump with link) sets next_pc to opa, sets link_we to 1 and link_rd to rd_idx.
- R9: taken is 1 for every jump code (7 to 10) and for branches whose condition holds, and 0 otherwise.
- R10: link_val is always pc+4, wrapping modulo 2^32. link_we is 0 and link_rd is 0 for every code other than 8 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Current program counter |
| kind | input | 4 | Control class code (see R1 to R8) |
| opa | input | 32 | First register operand; also the register jump target |
| opb | input | 32 | Second register operand |
| imm16 | input | 16 | Branch word offset field |
| tgt26 | input | 26 | Direct jump word target field |
| rd_idx | input | 5 | Named link destination for code 10 |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control leaves the sequential path |
| link_we | output | 1 | Return address register write enable |
| link_rd | output | 5 | Return address destination register |
| link_val | output | 32 | Return address (pc+4) |

## Verification
Every output is a combinational function of the inputs presented in the same cycle, so each result is due zero clock edges after its stimulus. The bench applies a vector just after a rising edge and compares all five outputs at the next falling edge. By then the inputs have had half a period to settle, and no register lies between the inputs and the outputs. Random vectors are biased toward equal operands, zero, negative values and a PC near the top of the address space, so that the equality, sign and wrap corners come up often.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int W = 32,
  parameter int RA_REG = 31
) (
  input  logic [W-1:0] pc,
  input  logic [3:0]   kind,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [15:0]  imm16,
  input  logic [25:0]  tgt26,
  input  logic [4:0]   rd_idx,
  output logic [W-1:0] next_pc,
  output logic         taken,
  output logic         link_we,
  output logic [4:0]   link_rd,
  output logic [W-1:0] link_val
);
  localparam logic [3:0] K_SEQ = 4'd0, K_BEQ = 4'd1, K_BNE = 4'd2, K_BGTZ = 4'd3,
                         K_BGEZ = 4'd4, K_BLTZ = 4'd5, K_BLEZ = 4'd6, K_J = 4'd7,
                         K_JAL = 4'd8, K_JR = 4'd9, K_JALR = 4'd10;
  localparam int OFS_PAD = W - 18;

  logic [W-1:0] seq, br_tgt, j_tgt;
  logic eq, zr, ng, cond, is_br;

  assign seq    = pc + W'(4);
  assign br_tgt = seq + {{OFS_PAD{imm16[15]}}, imm16, 2'b00};
  assign j_tgt  = {seq[W-1:W-4], tgt26, 2'b00};
  assign eq     = (opa == opb);
  assign zr     = (opa == '0);
  assign ng     = opa[W-1];
  assign link_val = seq;

  always_comb begin
    cond  = 1'b0;
    is_br = 1'b1;
    case (kind)
      K_BEQ:   cond = eq;
      K_BNE:   cond = !eq;
      K_BGTZ:  cond = !ng && !zr;
      K_BGEZ:  cond = !ng;
      K_BLTZ:  cond = ng;
      K_BLEZ:  cond = ng || zr;
      default: is_br = 1'b0;
    endcase
  end

  always_comb begin
    next_pc = seq;
    taken   = 1'b0;
    link_we = 1'b0;
    link_rd = '0;
    if (is_br && cond) begin
      next_pc = br_tgt;
      taken   = 1'b1;
    end
    case (kind)
      K_J:    begin next_pc = j_tgt; taken = 1'b1; end
      K_JAL:  begin next_pc = j_tgt; taken = 1'b1; link_we = 1'b1; link_rd = 5'(RA_REG); end
      K_JR:   begin next_pc = opa;   taken = 1'b1; end
      K_JALR: begin next_pc = opa;   taken = 1'b1; link_we = 1'b1; link_rd = rd_idx; end
      default: ;
    endcase
  end

  always_comb begin
    // R10
    link_only_chk: assert (!link_we || kind == K_JAL || kind == K_JALR);
    // R1
    seq_path_chk: assert (taken || next_pc == link_val);
    // R7
    ra_dest_chk: assert (!(kind == K_JAL) || (link_we && link_rd == 5'(RA_REG)));
    // R4
    br_only_cond_chk: assert (!(is_br && !cond) || (!taken && next_pc == seq));
    // R9
    jump_taken_chk: assert (!(kind >= K_J && kind <= K_JALR) || taken);
    // R1
    idle_chk: assert (!(kind == K_SEQ) || (!taken && !link_we && link_rd == '0));
  end
endmodule

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc, opa, opb;
  logic [3:0]  kind;
  logic [15:0] imm16;
  logic [25:0] tgt26;
  logic [4:0]  rd_idx;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_rd;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  next_pc_unit uut (.pc(pc), .kind(kind), .opa(opa), .opb(opb), .imm16(imm16),
    .tgt26(tgt26), .rd_idx(rd_idx), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_rd(link_rd), .link_val(link_val));

  function automatic string tag(input logic [3:0] k);
    case (k)
      4'd1, 4'd2: return "R2 R4 R9";
      4'd3, 4'd4, 4'd5, 4'd6: return "R3 R4 R9";
      4'd7: return "R5 R9 R10";
      4'd8: return "R7 R5 R9";
      4'd9: return "R6 R9 R10";
      4'd10: return "R8 R9";
      default: return "R1 R10";
    endcase
  endfunction

  function automatic logic [74:0] model(input logic [31:0] p, input logic [3:0] k,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
      input logic [25:0] tg, input logic [4:0] rd);
    logic [31:0] s, np;
    logic tk, we;
    logic [4:0] lr;
    logic signed [31:0] sa;
    s = p + 32'd4; sa = a; np = s; tk = 0; we = 0; lr = 0;
    case (k)
      4'd1: tk = (a == b);
      4'd2: tk = (a != b);
      4'd3: tk = (sa > 0);
      4'd4: tk = (sa >= 0);
      4'd5: tk = (sa < 0);
      4'd6: tk = (sa <= 0);
      default: ;
    endcase
    if (tk) np = s + (32'(signed'(im)) <<< 2);
    case (k)
      4'd7:  begin tk = 1; np = {s[31:28], tg, 2'b00}; end
      4'd8:  begin tk = 1; np = {s[31:28], tg, 2'b00}; we = 1; lr = 5'd31; end
      4'd9:  begin tk = 1; np = a; end
      4'd10: begin tk = 1; np = a; we = 1; lr = rd; end
      default: ;
    endcase
    return {np, tk, we, lr, s};
  endfunction

  task automatic apply(input logic [31:0] p, input logic [3:0] k, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] im, input logic [25:0] tg, input logic [4:0] rd);
    logic [74:0] exp, got;
    @(posedge clk); #1;
    pc = p; kind = k; opa = a; opb = b; imm16 = im; tgt26 = tg; rd_idx = rd;
    @(negedge clk);
    exp = model(p, k, a, b, im, tg, rd);
    got = {next_pc, taken, link_we, link_rd, link_val};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s kind=%0d actual np=%h tk=%b we=%b rd=%0d lv=%h expected np=%h tk=%b we=%b rd=%0d lv=%h",
        tag(k), k, got[74:43], got[42], got[41], got[40:36], got[31:0],
        exp[74:43], exp[42], exp[41], exp[40:36], exp[31:0]);
    end
  endtask

  function automatic logic [31:0] pick(input int sel);
    case (sel)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'd1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20130));
    // R1: idle vector with all-zero inputs
    apply(0, 4'd0, 0, 0, 0, 0, 0);
    // R10: wrap of pc+4
    apply(32'hFFFF_FFFC, 4'd0, 0, 0, 0, 0, 0);
    // R2: equal and unequal operands
    apply(32'h100, 4'd1, 32'h55, 32'h55, 16'h0003, 0, 0);
    apply(32'h100, 4'd1, 32'h55, 32'h54, 16'h0003, 0, 0);
    apply(32'h100, 4'd2, 32'h55, 32'h55, 16'h0003, 0, 0);
    apply(32'h100, 4'd2, 32'h55, 32'h54, 16'hFFFF, 0, 0);
    // R3: zero and sign boundaries
    for (int k = 3; k <= 6; k++) begin
      apply(32'h2000, 4'(k), 32'd0, 0, 16'h8000, 0, 0);
      apply(32'h2000, 4'(k), 32'd1, 0, 16'h7FFF, 0, 0);
      apply(32'h2000, 4'(k), 32'h8000_0000, 0, 16'hFFFE, 0, 0);
      apply(32'h2000, 4'(k), 32'hFFFF_FFFF, 0, 16'h0001, 0, 0);
    end
    // R4: negative offset crossing zero
    apply(32'h4, 4'd1, 0, 0, 16'hFFF0, 0, 0);
    // R5 R7: upper pc bits from pc+4 across a 256 MB boundary
    apply(32'h1FFF_FFFC, 4'd7, 0, 0, 0, 26'h3FF_FFFF, 0);
    apply(32'h1FFF_FFFC, 4'd8, 0, 0, 0, 26'h123_4567, 5'd7);
    // R6 R8
    apply(32'h300, 4'd9, 32'hDEAD_BEEC, 0, 0, 0, 5'd3);
    apply(32'h300, 4'd10, 32'h0000_1000, 0, 0, 0, 5'd17);
    apply(32'h300, 4'd10, 32'h0000_1000, 0, 0, 0, 5'd0);
    // R1: unused codes
    for (int k = 11; k <= 15; k++) apply(32'h500, 4'(k), 32'h1, 32'h1, 16'h10, 26'h5, 5'd9);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, p;
      a = pick($urandom_range(0, 8));
      b = ($urandom_range(0, 3) == 0) ? a : pick($urandom_range(0, 8));
      p = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 3) * 4) : {$urandom, 2'b00};
      apply(p, 4'($urandom_range(0, 15)), a, b, 16'($urandom), 26'($urandom), 5'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule